// File: doc/BRIEF.md
# Video Sync Timing Generator

This block produces the raster timing for a display from a host-programmed set of nineteen 12-bit registers. A clock counter runs across each line and a line counter runs down each frame. Comparing both counters against programmed start and end values gives horizontal and vertical sync and blank, composite sync and blank, a vertical interrupt window, and horizontal and vertical gate windows whose overlap forms a cursor.

Register 0 is the control word. Its low three bits pick which of eight signal sets appears on the four output pins. Four further bits set each pin's polarity. One bit turns on counting. That bit is clear after reset, so the raster stays halted until the host has programmed it. During a programmed band of lines, composite sync can carry equalization or serration pulses in place of the plain sync combination. Those pulses come once per line or twice per line.

The host writes one register per clock through `wr_en`, `wr_addr` and `wr_data`. Every write takes effect at the next clock edge.

Top module: `sync_timing_gen`

## Requirements
- R1: After reset every register and both counters are zero. With all signals inactive and every polarity bit 0, all four pins read 1.
- R2: While control bit 10 is 0, neither counter advances and the pins hold their value. After reset this bit is 0.
- R3: When control bit 10 is 1, the clock counter advances once per clock. It returns to 0 on the clock after it reaches register 4 minus one.
- R4: The line counter advances on each clock-counter wrap. It returns to 0 after line (register 8 minus one).
- R5: Horizontal blank is active while the clock count is below register 3. Horizontal sync is active from register 1 up to, but not including, register 2.
- R6: Vertical blank is active while the line count is below register 7. Vertical sync is active from register 5 up to, but not including, register 6.
- R7: Composite blank is the OR of horizontal and vertical blank. Outside the equalization band, composite sync is the XOR of horizontal and vertical sync.
- R8: Control bits [2:0] route signals to pins {pin3,pin2,pin1,pin0}, bit 0 of `sync_pins` being pin0:
  - 000 gives {VGATE,HGATE,CSYNC,CBLANK}.
  - 001 gives {VGATE,HBLANK,CSYNC,VBLANK}.
  - 010 gives {HSYNC,HGATE,VSYNC,CBLANK}.
  - 011 gives {HSYNC,HBLANK,VSYNC,VBLANK}.
  - 100 gives {VINT,CURSOR,CSYNC,CBLANK}.
  - 101 gives {VINT,HBLANK,CSYNC,VBLANK}.
  - 110 gives {HSYNC,CURSOR,VSYNC,CBLANK}.
  - 111 gives {HSYNC,HBLANK,VSYNC,VBLANK}.
- R9: Control bit 5+i sets the polarity of pin i. A 1 drives the active-high signal and a 0 drives it inverted.
- R10: The vertical interrupt is active for line counts from register 13 up to, but not including, register 14.
- R11: HGATE covers clock counts from register 15 up to, but not including, register 16. VGATE covers line counts from register 17 up to, but not including, register 18. CURSOR is HGATE AND VGATE.
- R12: The equalization band covers line counts from register 11 up to, but not including, register 12.
  - When control bit 9 is 0 and the line count is inside the band, composite sync is replaced by a pulse train.
  - Pulse width is register 10 on vertical-sync lines and register 9 on other lines.
  - A pulse starts at clock count 0.
  - Unless control bits [4:3] are 11, a second pulse starts at half the line length (register 4 shifted right by one).
- R13: Control bit 11 has no effect on any pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register index, 0 to 18 |
| wr_data | input | 12 | Register write value |
| sync_pins | output | 4 | Routed, polarity-adjusted timing outputs, bit i = pin i |

## Verification
Two cases land in the same cycle here. Vertical sync can coincide with the equalization band, and horizontal sync can coincide with vertical sync. In the first case the wider serration pulse must replace the equalization pulse. In the second case composite sync must fall to 0, because both inputs to the XOR are active. The bench halts the counters on line 2, which is both a sync line and a band line, and on a line where horizontal and vertical sync overlap. It then judges composite sync on the pin at the pulse edge and one count past it, with band substitution first switched on and then off.

// File: rtl/sync_timing_gen.sv
module sync_timing_gen #(
  parameter int W    = 12,
  parameter int AW   = 5,
  parameter int NREG = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  output logic [3:0]    sync_pins
);

  logic [W-1:0] cfg [NREG];
  logic [W-1:0] hcnt, vcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) cfg[i] <= '0;
    end else if (wr_en && int'(wr_addr) < NREG) begin
      cfg[int'(wr_addr)] <= wr_data;
    end
  end

  function automatic logic in_win(input logic [W-1:0] c, input logic [W-1:0] lo, input logic [W-1:0] hi);
    return (c >= lo) && (c < hi);
  endfunction

  logic [W-1:0] ctl, h_tot, v_tot;
  assign ctl   = cfg[0];
  assign h_tot = cfg[4];
  assign v_tot = cfg[8];

  logic run, h_last, v_last;
  assign run    = ctl[10];
  assign h_last = hcnt >= h_tot - W'(1);
  assign v_last = vcnt >= v_tot - W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (run) begin
      if (h_last) begin
        hcnt <= '0;
        vcnt <= v_last ? '0 : vcnt + W'(1);
      end else begin
        hcnt <= hcnt + W'(1);
      end
    end
  end

  logic hblank, hsync, vblank, vsync, vint, hgate, vgate, cursor;
  assign hblank = hcnt < cfg[3];
  assign hsync  = in_win(hcnt, cfg[1], cfg[2]);
  assign vblank = vcnt < cfg[7];
  assign vsync  = in_win(vcnt, cfg[5], cfg[6]);
  assign vint   = in_win(vcnt, cfg[13], cfg[14]);
  assign hgate  = in_win(hcnt, cfg[15], cfg[16]);
  assign vgate  = in_win(vcnt, cfg[17], cfg[18]);
  assign cursor = hgate & vgate;

  logic         eq_zone, dbl, pulse;
  logic [W-1:0] pw, half;
  logic [W:0]   half_end;
  assign eq_zone  = !ctl[9] && in_win(vcnt, cfg[11], cfg[12]);
  assign dbl      = ctl[4:3] != 2'b11;
  assign pw       = vsync ? cfg[10] : cfg[9];
  assign half     = h_tot >> 1;
  assign half_end = {1'b0, half} + {1'b0, pw};
  assign pulse    = (hcnt < pw) || (dbl && hcnt >= half && {1'b0, hcnt} < half_end);

  logic cblank, csync;
  assign cblank = hblank | vblank;
  assign csync  = eq_zone ? pulse : (hsync ^ vsync);

  logic [3:0] raw;
  always_comb begin
    raw[0] = ctl[0] ? vblank : cblank;
    raw[1] = ctl[1] ? vsync  : csync;
    raw[2] = ctl[0] ? hblank : (ctl[2] ? cursor : hgate);
    raw[3] = ctl[1] ? hsync  : (ctl[2] ? vint   : vgate);
  end

  assign sync_pins = raw ^ ~ctl[8:5];

  // R2
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(hcnt) && $stable(vcnt));

  // R2
  pins_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !wr_en |=> $stable(sync_pins));

  // R3
  hwrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && hcnt == h_tot - W'(1) |=> hcnt == '0);

  // R4
  vstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && h_last && !v_last |=> vcnt == $past(vcnt) + W'(1));

  // R4
  vwrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && hcnt == h_tot - W'(1) && vcnt == v_tot - W'(1) |=> vcnt == '0);

endmodule

// File: tb/sync_timing_gen_test.sv
module sync_timing_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int HT = 20;
  localparam int FRAME = 240;
  localparam int NV = 38;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic [3:0] sync_pins;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  sync_timing_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .sync_pins(sync_pins)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {tag, h, v, ctrl (run bit clear), expected pins}
  localparam logic [35:0] TBL [NV] = '{
    {4'd7,  8'd1,  8'd1,  12'h3E0, 4'b0001},   // R7 band off
    {4'd12, 8'd1,  8'd1,  12'h1E0, 4'b0011},   // R12 eq pulse
    {4'd12, 8'd2,  8'd1,  12'h1E0, 4'b0001},   // R12 eq edge
    {4'd12, 8'd11, 8'd1,  12'h1E0, 4'b0011},   // R12 second pulse
    {4'd12, 8'd11, 8'd1,  12'h1F8, 4'b0001},   // R12 single mode
    {4'd12, 8'd12, 8'd1,  12'h1E0, 4'b0101},   // R12 after second
    {4'd12, 8'd4,  8'd2,  12'h1E0, 4'b0011},   // R12 serration
    {4'd13, 8'd4,  8'd2,  12'h9E0, 4'b0011},   // R13 test bit
    {4'd12, 8'd5,  8'd2,  12'h1E0, 4'b0001},   // R12 serration end
    {4'd7,  8'd3,  8'd3,  12'h3E0, 4'b0011},   // R7
    {4'd8,  8'd3,  8'd3,  12'h3E3, 4'b0111},   // R8
    {4'd10, 8'd3,  8'd3,  12'h3E4, 4'b0011},   // R10 off
    {4'd7,  8'd5,  8'd3,  12'h3E0, 4'b0001},   // R7 both syncs
    {4'd8,  8'd5,  8'd8,  12'h3E0, 4'b1011},   // R8 mode sweep
    {4'd8,  8'd5,  8'd8,  12'h3E1, 4'b1110},
    {4'd8,  8'd5,  8'd8,  12'h3E2, 4'b1001},
    {4'd8,  8'd5,  8'd8,  12'h3E3, 4'b1100},
    {4'd8,  8'd5,  8'd8,  12'h3E4, 4'b1011},
    {4'd8,  8'd5,  8'd8,  12'h3E5, 4'b1110},
    {4'd8,  8'd5,  8'd8,  12'h3E6, 4'b1001},
    {4'd8,  8'd5,  8'd8,  12'h3E7, 4'b1100},
    {4'd9,  8'd5,  8'd8,  12'h200, 4'b0100},   // R9 all low
    {4'd9,  8'd5,  8'd8,  12'h2A0, 4'b0001},   // R9 mixed
    {4'd11, 8'd12, 8'd8,  12'h3E4, 4'b1100},   // R11 cursor on
    {4'd11, 8'd12, 8'd8,  12'h3E6, 4'b0100},
    {4'd11, 8'd16, 8'd8,  12'h3E6, 4'b0000},   // R11 h end
    {4'd11, 8'd12, 8'd9,  12'h3E6, 4'b0000},   // R11 v end
    {4'd11, 8'd12, 8'd9,  12'h3E0, 4'b0100},
    {4'd8,  8'd13, 8'd9,  12'h3E0, 4'b0100},
    {4'd10, 8'd13, 8'd9,  12'h3E4, 4'b1000},   // R10 on
    {4'd10, 8'd13, 8'd9,  12'h3E5, 4'b1000},
    {4'd10, 8'd0,  8'd10, 12'h3E4, 4'b0001},   // R10 end
    {4'd5,  8'd19, 8'd10, 12'h3E3, 4'b0000},   // R5
    {4'd3,  8'd0,  8'd11, 12'h3E3, 4'b0100},   // R3 wrap
    {4'd5,  8'd4,  8'd11, 12'h3E3, 4'b1100},   // R5 sync
    {4'd4,  8'd0,  8'd0,  12'h3E3, 4'b0101},   // R4 frame wrap
    {4'd6,  8'd0,  8'd2,  12'h3E3, 4'b0111},   // R6 vsync
    {4'd6,  8'd0,  8'd4,  12'h3E3, 4'b0101}    // R6 vsync end
  };

  task automatic wr(input int a, input logic [11:0] d);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check(input int req, input logic [3:0] exp);
    checks++;
    if (sync_pins !== exp) begin
      errors++;
      $display("FAIL R%0d pins actual %b expected %b", req, sync_pins, exp);
    end
  endtask

  task automatic go(input int d, input logic [11:0] c);
    if (d > 0) begin
      wr(0, c | 12'h400);
      repeat (d - 1) @(negedge clk);
    end
    wr(0, c);
  endtask

  initial begin
    int cur;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(1, 4'b1111); // R1

    wr(1, 12'd4);  wr(2, 12'd7);  wr(3, 12'd10); wr(4, 12'd20);
    wr(5, 12'd2);  wr(6, 12'd4);  wr(7, 12'd6);  wr(8, 12'd12);
    wr(9, 12'd2);  wr(10, 12'd5); wr(11, 12'd1); wr(12, 12'd5);
    wr(13, 12'd8); wr(14, 12'd10);
    wr(15, 12'd12); wr(16, 12'd16); wr(17, 12'd7); wr(18, 12'd9);
    repeat (5) @(negedge clk);
    check(2, 4'b1110); // R2 default halt

    cur = 0;
    for (int i = 0; i < NV; i++) begin
      int p, d;
      p = int'(TBL[i][31:24]) + HT * int'(TBL[i][23:16]);
      d = (p - cur + FRAME) % FRAME;
      go(d, TBL[i][15:4]);
      cur = p;
      check(int'(TBL[i][35:32]), TBL[i][3:0]);
    end

    repeat (7) @(negedge clk);
    check(2, 4'b0101); // R2 hold while halted

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule